// File: doc/BRIEF.md
# Expansion DRAM Bus Controller for a 68000-Style Bus

This block connects a 68000-style asynchronous bus to a local dynamic RAM that serves as expansion memory. It runs from a fast reference clock that is synchronous to the CPU clock. First it passes the bus control inputs through two-flop synchronisers. It then checks whether the word address falls inside the expansion window. If it does, the block runs a row/column sequence on the memory with per-byte column strobes, and finally pulls the active-low data acknowledge low.

On reads the acknowledge is held back for a few extra reference clocks after the memory data has been captured and driven. The data is therefore stable before the CPU can see the acknowledge, which gives the CPU one full wait state. Each time the address strobe goes inactive, the block starts a CAS-before-RAS refresh in the gap before the next cycle. An access that arrives during a refresh waits until the refresh ends. An interval counter forces a refresh if the bus stays busy for too long.

Top module: `fastram_ctrl`

## Requirements
- R1: While reset is held and right after it, dtackN, rasN, both bits of casN and memWeN are high, and cpuDataOe is low.
- R2: A bus cycle whose address bits [22:20] differ from the window select (default 3'b001) produces no acknowledge and no memory write.
- R3: For a window read, dtackN goes low after the 9th rising reference clock edge that follows the fall of asN. With the default parameters this is 3 + RAS_CYC(2) + CAS_CYC(2) + READ_WAIT(2).
- R4: Read data is driven on cpuDataOut with cpuDataOe high at least one reference clock before dtackN falls. The word is the one stored at the addressed location.
- R5: For a window write, dtackN goes low after the 7th rising edge that follows the fall of asN, and memWeN is only ever low while rasN is low.
- R6: A write strobes only the column lines of active byte lanes. casN[1] is the upper lane (udsN, data bits 15:8) and casN[0] is the lower lane (ldsN, bits 7:0). Inactive lanes keep their stored byte.
- R7: dtackN returns high and cpuDataOe returns low without waiting for a clock edge once asN goes high.
- R8: After a window cycle ends, both casN bits fall with rasN high after the 3rd rising edge following the rise of asN. rasN falls one clock later, and memWeN stays high throughout.
- R9: An access whose asN falls during a refresh is delayed beyond the nominal latency and still returns correct data. dtackN is never low while any casN bit is low with rasN high.
- R10: If asN stays low for longer than REF_INTERVAL (default 40) reference clocks, a refresh is started without waiting for the cycle to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, synchronous to the CPU clock |
| rstN | input | 1 | Active-low asynchronous reset |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper byte data strobe, active low |
| ldsN | input | 1 | Lower byte data strobe, active low |
| rnw | input | 1 | High for read, low for write |
| addr | input | 23 | CPU word address (A23..A1) |
| cpuDataIn | input | 16 | Write data from the CPU |
| cpuDataOut | output | 16 | Read data to the CPU |
| cpuDataOe | output | 1 | Enables the read data drivers |
| dtackN | output | 1 | Data acknowledge, active low |
| memAddr | output | 10 | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 2 | Column strobes, bit 1 upper lane, bit 0 lower lane |
| memWeN | output | 1 | Memory write enable, active low |
| memDataOut | output | 16 | Write data to memory |
| memDataIn | input | 16 | Read data from memory |

## Verification
Inputs change on the falling clock edge. Each latency is then counted as the number of rising edges before the output shows the change: 9 for a read acknowledge, 7 for a write acknowledge, 3 from the end of the address strobe to the refresh column strobes, and none for release of the acknowledge. The bench samples every result at the falling edge that follows the edge on which the result is due. It checks read data and the output enable at the falling edge just before the acknowledge. A stalled access is checked against a lower bound, not an exact count, because its delay depends on how much of the refresh remains.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFC,
    ST_REFR,
    ST_RAS,
    ST_CAS,
    ST_RWAIT,
    ST_HOLD
  } frStateT;

  typedef struct packed {
    logic rasOn;
    logic casOn;
    logic refCas;
    logic useCol;
    logic weOn;
    logic latchRd;
    logic oeOn;
    logic ackOn;
    logic laneU;
    logic laneL;
  } frStrobeT;

endpackage

// File: rtl/fr_ctrl.sv
module fr_ctrl
  import fr_pkg::*;
#(
  parameter int RAS_CYC      = 2,
  parameter int CAS_CYC      = 2,
  parameter int READ_WAIT    = 2,
  parameter int REF_CYC      = 3,
  parameter int REF_INTERVAL = 40
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     asN,
  input  logic     udsN,
  input  logic     ldsN,
  input  logic     rnw,
  input  logic     winHit,
  output frStrobeT strb
);
  localparam int CNT_W = $clog2(RAS_CYC + CAS_CYC + READ_WAIT + REF_CYC + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  logic asQ, asAct, udsQ, udsAct, ldsQ, ldsAct, rnwQ, rnwAct;
  logic asPrev, readOp, laneU, laneL;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refCnt;
  frStateT state;
  logic refDue, asEnded, cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asQ <= 1'b0; asAct <= 1'b0;
      udsQ <= 1'b0; udsAct <= 1'b0;
      ldsQ <= 1'b0; ldsAct <= 1'b0;
      rnwQ <= 1'b1; rnwAct <= 1'b1;
    end else begin
      asQ <= ~asN;   asAct <= asQ;
      udsQ <= ~udsN; udsAct <= udsQ;
      ldsQ <= ~ldsN; ldsAct <= ldsQ;
      rnwQ <= rnw;   rnwAct <= rnwQ;
    end
  end

  assign refDue  = (refCnt == REF_W'(REF_INTERVAL));
  assign asEnded = asPrev & ~asAct;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      refCnt <= '0;
      asPrev <= 1'b0;
      readOp <= 1'b1;
      laneU  <= 1'b0;
      laneL  <= 1'b0;
    end else begin
      asPrev <= asAct;
      if (state == ST_REFC) refCnt <= '0;
      else if (!refDue)     refCnt <= refCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (refDue || asEnded) begin
            state <= ST_REFC;
          end else if (asAct && winHit && (udsAct || ldsAct)) begin
            state  <= ST_RAS;
            cnt    <= CNT_W'(RAS_CYC - 1);
            readOp <= rnwAct;
          end
        end
        ST_REFC: begin
          state <= ST_REFR;
          cnt   <= CNT_W'(REF_CYC - 1);
        end
        ST_REFR: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_RAS: begin
          if (cntZero) begin
            state <= ST_CAS;
            cnt   <= CNT_W'(CAS_CYC - 1);
            laneU <= udsAct | readOp;
            laneL <= ldsAct | readOp;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CAS: begin
          if (cntZero) begin
            if (readOp) begin
              state <= ST_RWAIT;
              cnt   <= CNT_W'(READ_WAIT - 1);
            end else begin
              state <= ST_HOLD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RWAIT: begin
          if (cntZero) state <= ST_HOLD;
          else         cnt   <= cnt - 1'b1;
        end
        ST_HOLD: begin
          if (!asAct) state <= ST_REFC;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.rasOn   = (state == ST_RAS) || (state == ST_CAS) || (state == ST_REFR);
    strb.casOn   = (state == ST_CAS);
    strb.refCas  = (state == ST_REFC) || (state == ST_REFR);
    strb.useCol  = (state == ST_CAS);
    strb.weOn    = (state == ST_CAS) && !readOp;
    strb.latchRd = (state == ST_CAS) && cntZero && readOp;
    strb.oeOn    = ((state == ST_RWAIT) || (state == ST_HOLD)) && readOp;
    strb.ackOn   = (state == ST_HOLD);
    strb.laneU   = laneU;
    strb.laneL   = laneL;
  end

endmodule

// File: rtl/fr_datapath.sv
module fr_datapath
  import fr_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int ROW_W    = 10,
  parameter int WIN_BITS = 3,
  parameter logic [WIN_BITS-1:0] WIN_SEL = 3'b001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       cpuDataIn,
  input  logic [15:0]       memDataIn,
  input  frStrobeT          strb,
  output logic              winHit,
  output logic [15:0]       cpuDataOut,
  output logic              cpuDataOe,
  output logic              dtackN,
  output logic [ROW_W-1:0]  memAddr,
  output logic              rasN,
  output logic [1:0]        casN,
  output logic              memWeN,
  output logic [15:0]       memDataOut
);
  localparam int LANES = 2;

  logic [ROW_W-1:0] rowPart, colPart;
  logic [LANES-1:0] laneOn;
  logic [7:0]       rdLane [LANES];

  assign winHit  = (addr[ADDR_W-1 -: WIN_BITS] == WIN_SEL);
  assign rowPart = addr[2*ROW_W-1:ROW_W];
  assign colPart = addr[ROW_W-1:0];
  assign memAddr = strb.useCol ? colPart : rowPart;
  assign laneOn  = {strb.laneU, strb.laneL};

  assign rasN       = ~strb.rasOn;
  assign memWeN     = ~strb.weOn;
  assign memDataOut = cpuDataIn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign casN[g] = ~((strb.casOn & laneOn[g]) | strb.refCas);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdLane[g] <= '0;
      else if (strb.latchRd) rdLane[g] <= memDataIn[g*8 +: 8];
    end
  end

  assign cpuDataOut = {rdLane[1], rdLane[0]};
  assign cpuDataOe  = strb.oeOn & ~asN;
  assign dtackN     = ~(strb.ackOn & ~asN);

endmodule

// File: rtl/fastram_ctrl.sv
module fastram_ctrl
  import fr_pkg::*;
#(
  parameter int ADDR_W       = 23,
  parameter int ROW_W        = 10,
  parameter int WIN_BITS     = 3,
  parameter logic [WIN_BITS-1:0] WIN_SEL = 3'b001,
  parameter int RAS_CYC      = 2,
  parameter int CAS_CYC      = 2,
  parameter int READ_WAIT    = 2,
  parameter int REF_CYC      = 3,
  parameter int REF_INTERVAL = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       cpuDataIn,
  output logic [15:0]       cpuDataOut,
  output logic              cpuDataOe,
  output logic              dtackN,
  output logic [ROW_W-1:0]  memAddr,
  output logic              rasN,
  output logic [1:0]        casN,
  output logic              memWeN,
  output logic [15:0]       memDataOut,
  input  logic [15:0]       memDataIn
);
  frStrobeT strb;
  logic     winHit;

  fr_ctrl #(
    .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC), .READ_WAIT(READ_WAIT),
    .REF_CYC(REF_CYC), .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .rnw(rnw), .winHit(winHit), .strb(strb)
  );

  fr_datapath #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .WIN_BITS(WIN_BITS), .WIN_SEL(WIN_SEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .asN(asN), .addr(addr), .cpuDataIn(cpuDataIn),
    .memDataIn(memDataIn), .strb(strb), .winHit(winHit),
    .cpuDataOut(cpuDataOut), .cpuDataOe(cpuDataOe), .dtackN(dtackN),
    .memAddr(memAddr), .rasN(rasN), .casN(casN), .memWeN(memWeN),
    .memDataOut(memDataOut)
  );

endmodule

// File: rtl/fr_checks.sv
module fr_checks (
  input logic       clk,
  input logic       rstN,
  input logic       rnw,
  input logic       dtackN,
  input logic       rasN,
  input logic [1:0] casN,
  input logic       memWeN,
  input logic       cpuDataOe
);
  AST_WE_UNDER_ROW: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !rasN); // R5

  AST_WE_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (casN != 2'b11)); // R6

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && (casN != 2'b11)) |-> ($past(casN == 2'b00) && memWeN)); // R8

  AST_NO_ACK_IN_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && (casN != 2'b11)) |-> dtackN); // R9

  AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dtackN) && rnw) |-> $past(cpuDataOe)); // R4

endmodule

bind fastram_ctrl fr_checks u_checks (
  .clk(clk), .rstN(rstN), .rnw(rnw), .dtackN(dtackN), .rasN(rasN),
  .casN(casN), .memWeN(memWeN), .cpuDataOe(cpuDataOe)
);

// File: tb/sim_fastram_ctrl.sv
module sim_fastram_ctrl;
  localparam int READ_LAT  = 9;
  localparam int WRITE_LAT = 7;
  localparam int REF_INT   = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asN = 1'b1, udsN = 1'b1, ldsN = 1'b1, rnw = 1'b1;
  logic [22:0] addr = '0;
  logic [15:0] cpuDataIn = '0;
  logic [15:0] cpuDataOut, memDataOut, memDataIn;
  logic        cpuDataOe, dtackN, rasN, memWeN;
  logic [9:0]  memAddr;
  logic [1:0]  casN;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;

  fastram_ctrl u0 (
    .clk(clk), .rstN(rstN), .asN(asN), .udsN(udsN), .ldsN(ldsN), .rnw(rnw),
    .addr(addr), .cpuDataIn(cpuDataIn), .cpuDataOut(cpuDataOut),
    .cpuDataOe(cpuDataOe), .dtackN(dtackN), .memAddr(memAddr), .rasN(rasN),
    .casN(casN), .memWeN(memWeN), .memDataOut(memDataOut), .memDataIn(memDataIn)
  );

  // DRAM model sampled mid-cycle
  logic [15:0] mem [0:1023];
  logic [9:0]  rowL = '0;
  logic        rasPrev = 1'b1;
  logic [9:0]  idx;
  assign idx = {rowL[4:0], memAddr[4:0]};
  assign memDataIn = mem[idx];

  initial for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!rasN && rasPrev && casN == 2'b11) rowL <= memAddr;
    if (!rasN && !memWeN) begin
      if (!casN[1]) mem[idx][15:8] <= memDataOut[15:8];
      if (!casN[0]) mem[idx][7:0]  <= memDataOut[7:0];
    end
    rasPrev <= rasN;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] winAddr(input int row, input int col);
    return {3'b001, 10'(row), 10'(col)};
  endfunction

  // Ends a cycle: R7 release check, optional R8 refresh check, then idle gap
  task automatic endCycle(input int gap);
    @(negedge clk);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    #1;
    check(dtackN === 1'b1 && cpuDataOe === 1'b0, "R7 release", {dtackN, cpuDataOe}, 2);
    if (gap >= 4) begin
      repeat (2) @(negedge clk);
      @(negedge clk);
      check(casN === 2'b00 && rasN === 1'b1, "R8 cas first", {casN, rasN}, 1);
      @(negedge clk);
      check(rasN === 1'b0 && memWeN === 1'b1, "R8 ras follows", {rasN, memWeN}, 1);
      repeat (gap - 4) @(negedge clk);
    end else begin
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic busWrite(input logic [22:0] a, input logic [15:0] d,
                          input logic upper, input logic lower, input int gap);
    int lat;
    @(negedge clk);
    addr = a; cpuDataIn = d; rnw = 1'b0;
    asN = 1'b0; udsN = ~upper; ldsN = ~lower;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!dtackN) break;
    end
    check(lat == WRITE_LAT, "R5 write ack latency", lat, WRITE_LAT);
    endCycle(gap);
  endtask

  task automatic busRead(input logic [22:0] a, input logic [15:0] exp,
                         input logic stalled, input int gap);
    int lat;
    logic prevOe;
    logic [15:0] prevData;
    logic sawRefAck;
    @(negedge clk);
    addr = a; rnw = 1'b1; asN = 1'b0; udsN = 1'b0; ldsN = 1'b0;
    lat = 0; prevOe = 1'b0; prevData = '0; sawRefAck = 1'b0;
    for (int k = 0; k < 100; k++) begin
      prevOe = cpuDataOe; prevData = cpuDataOut;
      @(posedge clk); lat++;
      @(negedge clk);
      if (rasN && casN != 2'b11 && !dtackN) sawRefAck = 1'b1;
      if (!dtackN) break;
    end
    if (stalled) begin
      check(lat > READ_LAT, "R9 stalled latency", lat, READ_LAT + 1);
      check(!sawRefAck, "R9 no ack in refresh", int'(sawRefAck), 0);
      check(cpuDataOut === exp, "R9 stalled data", cpuDataOut, exp);
    end else begin
      check(lat == READ_LAT, "R3 read ack latency", lat, READ_LAT);
      check(prevOe === 1'b1 && prevData === exp, "R4 data before ack", prevData, exp);
    end
    check(cpuDataOe === 1'b1 && cpuDataOut === exp, "R4 data at ack", cpuDataOut, exp);
    endCycle(gap);
  endtask

  task automatic testReset();
    check(dtackN === 1'b1 && rasN === 1'b1 && casN === 2'b11 && memWeN === 1'b1
          && cpuDataOe === 1'b0, "R1 reset outputs",
          {dtackN, rasN, casN, memWeN, cpuDataOe}, 6'b111110);
  endtask

  task automatic testWordRoundTrip();
    busWrite(winAddr(5, 3), 16'hBEEF, 1'b1, 1'b1, 10);
    busRead(winAddr(5, 3), 16'hBEEF, 1'b0, 10);
    busWrite(winAddr(7, 12), 16'h1234, 1'b1, 1'b1, 10);
    busRead(winAddr(7, 12), 16'h1234, 1'b0, 10);
  endtask

  task automatic testByteLanes();
    busWrite(winAddr(2, 9), 16'h1111, 1'b1, 1'b1, 10);
    busWrite(winAddr(2, 9), 16'hAB22, 1'b1, 1'b0, 10);
    busRead(winAddr(2, 9), 16'hAB11, 1'b0, 10);  // R6 upper only
    busWrite(winAddr(2, 9), 16'h33CD, 1'b0, 1'b1, 10);
    busRead(winAddr(2, 9), 16'hABCD, 1'b0, 10);  // R6 lower only
  endtask

  task automatic testOutsideWindow();
    logic sawAck, sawWe;
    sawAck = 1'b0; sawWe = 1'b0;
    @(negedge clk);
    addr = {3'b011, 10'd5, 10'd3}; cpuDataIn = 16'h5A5A; rnw = 1'b0;
    asN = 1'b0; udsN = 1'b0; ldsN = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!dtackN) sawAck = 1'b1;
      if (!memWeN) sawWe = 1'b1;
    end
    check(!sawAck, "R2 no ack outside window", int'(sawAck), 0);
    check(!sawWe, "R2 no write outside window", int'(sawWe), 0);
    endCycle(10);
    busRead(winAddr(5, 3), 16'hBEEF, 1'b0, 10);  // R2 memory unchanged
  endtask

  task automatic testStall();
    busWrite(winAddr(9, 1), 16'hC0DE, 1'b1, 1'b1, 2);
    busRead(winAddr(9, 1), 16'hC0DE, 1'b1, 10);
  endtask

  task automatic testForcedRefresh();
    int first;
    first = -1;
    @(negedge clk);
    addr = {3'b100, 20'd0}; rnw = 1'b1; asN = 1'b0; udsN = 1'b0; ldsN = 1'b0;
    for (int k = 1; k <= REF_INT + 30; k++) begin
      @(negedge clk);
      if (first < 0 && casN == 2'b00 && rasN) first = k;
    end
    check(first > 0 && first <= REF_INT + 4, "R10 forced refresh", first, REF_INT);
    endCycle(10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordRoundTrip();
    testByteLanes();
    testOutsideWindow();
    testStall();
    testForcedRefresh();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule